// File: doc/BRIEF.md
# Read-Only Serial Converter Output Port

This block is the digital output side of a pin-configured 24-bit measurement converter that software never writes. A behavioural conversion timer runs while the active-low select input is held low. At the end of every period it captures a 24-bit offset-binary code from one of two stimulus inputs. The static channel pin chooses the input and the static range pin chooses the gain. The code is then offered on a single line that serves as both the ready flag and the serial data.

The mode pin picks who owns the serial clock. In master mode the block produces exactly 24 clock periods for each result. In slave mode a host supplies the clock, and the block resynchronises that clock into its own clock domain. Raising the select input stops everything at once: both pin drivers release, the timer restarts from zero, and any result that was not read is thrown away. A result that completes during a readout is parked in a one-entry holding register. It is offered once the current readout has finished.

Top module: `ro_adc_serial_port`

## Requirements
- R1: Codes are DATA_W (24) bits, offset binary (0x800000 is zero). With range_sel=0 the captured code equals the stimulus. With range_sel=1 the signed value (code XOR 0x800000) is multiplied by 16 and saturates to 0x000000 or 0xFFFFFF.
- R2: chan_sel=0 selects sample_a and chan_sel=1 selects sample_b. Both pins are sampled when a conversion starts and are held until that conversion completes. No other path sets them.
- R3: While cs_n is low, conversions follow each other every CONV_CYCLES clock cycles. sdo_o falls after the (CONV_CYCLES+1)-th rising clk edge that sees cs_n low.
- R4: sdo_o rests high while no result is pending and goes low while a result waits to be read.
- R5: In master mode (mode_slave=0), sclk_oe is high under select. sclk_o rests high and gives exactly 24 low-then-high periods per result, then stops.
- R6: Bits leave MSB first. A bit changes with a falling serial clock edge and is steady at the following rising edge, in both modes.
- R7: In slave mode (mode_slave=1), sclk_oe stays low. The block shifts one bit per falling edge of sclk_i, and clock pulses after the 24th are ignored.
- R8: One clk cycle after the 24th rising serial edge is seen, sdo_o returns high until another result is ready.
- R9: A result completing during a readout leaves the bits being read intact. It becomes ready right after that readout ends.
- R10: With cs_n high, sdo_oe and sclk_oe are low. An unread or partly read result is discarded and the conversion timer restarts from zero at the next select.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock (reference clock of the timer) |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Active-low select; high means standby |
| mode_slave | input | 1 | 0: block drives serial clock, 1: host drives it |
| chan_sel | input | 1 | Static channel pin (0: sample_a, 1: sample_b) |
| range_sel | input | 1 | Static range pin (0: gain 1, 1: gain 16) |
| sample_a | input | DATA_W | Stimulus code for channel 0 |
| sample_b | input | DATA_W | Stimulus code for channel 1 |
| sclk_i | input | 1 | Host serial clock (slave mode) |
| sclk_o | output | 1 | Generated serial clock (master mode) |
| sclk_oe | output | 1 | Drive enable for sclk_o |
| sdo_o | output | 1 | Combined ready flag and serial data |
| sdo_oe | output | 1 | Drive enable for sdo_o |

## Verification
The ready flag is due exactly CONV_CYCLES+1 clock edges after select falls. The bench counts that many edges and samples there, both at the first cycle where the flag may change and at the cycle before it. In master mode a bit is taken at the first falling clk edge after sclk_o is seen to rise. sdo_o is expected high one clk cycle later. In slave mode a host clock edge takes three clk edges to act, so the bench waits six cycles of each half period before it samples or moves on. The enables follow cs_n without delay and are checked in the same cycle.

// File: rtl/adcro_pkg.sv
package adcro_pkg;
    // Readout sequencer states; LAST holds the final bit for one extra cycle
    typedef enum logic [1:0] {
        RD_IDLE  = 2'd0,
        RD_READY = 2'd1,
        RD_SHIFT = 2'd2,
        RD_LAST  = 2'd3
    } rd_state_e;
endpackage

// File: rtl/adcro_conv_timer.sv
module adcro_conv_timer #(
    parameter int DATA_W      = 24,
    parameter int CONV_CYCLES = 1656,
    parameter int GAIN_SHIFT  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              chan_sel,
    input  logic              range_sel,
    input  logic [DATA_W-1:0] sample_a,
    input  logic [DATA_W-1:0] sample_b,
    output logic              done_o,
    output logic [DATA_W-1:0] data_o
);
    localparam int CNT_W  = $clog2(CONV_CYCLES);
    localparam int PROD_W = DATA_W + GAIN_SHIFT;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(CONV_CYCLES - 1);

    typedef struct packed {
        logic [CNT_W-1:0]  cnt;
        logic              chan;
        logic              rng;
        logic              done;
        logic [DATA_W-1:0] data;
    } tmr_t;

    tmr_t tmr_d, tmr_q;

    logic [DATA_W-1:0]        raw_code;
    logic [DATA_W-1:0]        scaled_code;
    logic signed [DATA_W-1:0] centred;
    logic signed [PROD_W-1:0] widened;
    logic signed [PROD_W-1:0] product;
    logic [GAIN_SHIFT:0]      head_bits;
    logic                     overflow;

    // Gain model in the signed domain, then back to offset binary (R1)
    always_comb begin
        raw_code  = tmr_q.chan ? sample_b : sample_a;
        centred   = {~raw_code[DATA_W-1], raw_code[DATA_W-2:0]};
        widened   = {{GAIN_SHIFT{centred[DATA_W-1]}}, centred};
        product   = widened <<< GAIN_SHIFT;
        head_bits = product[PROD_W-1:DATA_W-1];
        overflow  = (|head_bits) && !(&head_bits);
        if (!tmr_q.rng) begin
            scaled_code = raw_code;
        end else if (overflow) begin
            scaled_code = product[PROD_W-1] ? '0 : '1;
        end else begin
            scaled_code = {~product[DATA_W-1], product[DATA_W-2:0]};
        end
    end

    // Period counter; pins are latched at each conversion start (R2, R3)
    always_comb begin
        tmr_d      = tmr_q;
        tmr_d.done = 1'b0;
        if (cs_n) begin
            tmr_d.cnt  = '0;
            tmr_d.chan = chan_sel;
            tmr_d.rng  = range_sel;
        end else if (tmr_q.cnt == CNT_LAST) begin
            tmr_d.cnt  = '0;
            tmr_d.done = 1'b1;
            tmr_d.data = scaled_code;
            tmr_d.chan = chan_sel;
            tmr_d.rng  = range_sel;
        end else begin
            tmr_d.cnt = tmr_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tmr_q <= '0;
        else        tmr_q <= tmr_d;
    end

    assign done_o = tmr_q.done;
    assign data_o = tmr_q.data;

    // R3: a result strobe lasts one cycle and only follows a selected cycle
    p_done_gap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_q.done |=> !tmr_q.done);
    p_done_selected_r3: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_q.done |-> !$past(cs_n));
endmodule

// File: rtl/adcro_master_clk.sv
module adcro_master_clk #(
    parameter int HALF_DIV = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic active_i,
    output logic sclk_o,
    output logic fall_o,
    output logic rise_o
);
    localparam int HW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
    localparam logic [HW-1:0] HALF_LAST = HW'(HALF_DIV - 1);

    typedef struct packed {
        logic [HW-1:0] cnt;
        logic          sclk;
    } mclk_t;

    localparam mclk_t MCLK_RST = '{cnt: '0, sclk: 1'b1};

    mclk_t mclk_d, mclk_q;
    logic  toggle;

    always_comb begin
        toggle = active_i && (mclk_q.cnt == HALF_LAST);
        fall_o = toggle && mclk_q.sclk;
        rise_o = toggle && !mclk_q.sclk;
        mclk_d = mclk_q;
        if (!active_i) begin
            mclk_d = MCLK_RST;
        end else if (toggle) begin
            mclk_d.cnt  = '0;
            mclk_d.sclk = !mclk_q.sclk;
        end else begin
            mclk_d.cnt = mclk_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mclk_q <= MCLK_RST;
        else        mclk_q <= mclk_d;
    end

    assign sclk_o = mclk_q.sclk;

    // R5: the generated clock parks high once the sequencer releases it
    p_clock_parks_high_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !active_i |=> mclk_q.sclk);
endmodule

// File: rtl/adcro_slave_sync.sv
module adcro_slave_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk_i,
    output logic fall_o,
    output logic rise_o
);
    localparam int PIPE_W = SYNC_STAGES + 1;

    logic [PIPE_W-1:0] pipe_d, pipe_q;

    always_comb begin
        pipe_d = {pipe_q[PIPE_W-2:0], sclk_i};
        fall_o = pipe_q[PIPE_W-1] && !pipe_q[PIPE_W-2];
        rise_o = !pipe_q[PIPE_W-1] && pipe_q[PIPE_W-2];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe_q <= '1;
        else        pipe_q <= pipe_d;
    end
endmodule

// File: rtl/adcro_shifter.sv
module adcro_shifter
    import adcro_pkg::*;
#(
    parameter int DATA_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              done_i,
    input  logic [DATA_W-1:0] data_i,
    input  logic              fall_i,
    input  logic              rise_i,
    output logic              sdo_o,
    output logic              busy_o
);
    localparam int BW = $clog2(DATA_W + 1);
    localparam logic [BW-1:0] BIT_COUNT = BW'(DATA_W);
    localparam logic [BW-1:0] BIT_FINAL = BW'(DATA_W - 1);

    typedef struct packed {
        rd_state_e         state;
        logic [DATA_W-1:0] sreg;
        logic              sdo;
        logic [BW-1:0]     falls;
        logic [BW-1:0]     rises;
        logic              pend;
        logic [DATA_W-1:0] pend_data;
    } shift_t;

    localparam shift_t SH_RST = '{state: RD_IDLE, sreg: '0, sdo: 1'b1,
                                  falls: '0, rises: '0, pend: 1'b0,
                                  pend_data: '0};

    shift_t sh_d, sh_q;

    always_comb begin
        sh_d = sh_q;
        if (cs_n) begin
            // R10: standby drops any held or partly read result
            sh_d.state = RD_IDLE;
            sh_d.sdo   = 1'b1;
            sh_d.pend  = 1'b0;
            sh_d.falls = '0;
            sh_d.rises = '0;
            sh_d.sreg  = '0;
        end else begin
            case (sh_q.state)
                RD_IDLE: begin
                    if (done_i || sh_q.pend) begin
                        sh_d.state = RD_READY;
                        sh_d.sdo   = 1'b0;
                        sh_d.falls = '0;
                        sh_d.rises = '0;
                        sh_d.sreg  = done_i ? data_i : sh_q.pend_data;
                        sh_d.pend  = 1'b0;
                    end
                end
                RD_READY, RD_SHIFT: begin
                    if (done_i) begin
                        sh_d.pend      = 1'b1;
                        sh_d.pend_data = data_i;
                    end
                    if (fall_i && (sh_q.falls < BIT_COUNT)) begin
                        sh_d.sdo   = sh_q.sreg[DATA_W-1];
                        sh_d.sreg  = {sh_q.sreg[DATA_W-2:0], 1'b0};
                        sh_d.falls = sh_q.falls + 1'b1;
                        sh_d.state = RD_SHIFT;
                    end else if (rise_i && (sh_q.state == RD_SHIFT) &&
                                 (sh_q.rises < sh_q.falls)) begin
                        sh_d.rises = sh_q.rises + 1'b1;
                        if (sh_q.rises == BIT_FINAL) sh_d.state = RD_LAST;
                    end
                end
                RD_LAST: begin
                    if (done_i) begin
                        sh_d.pend      = 1'b1;
                        sh_d.pend_data = data_i;
                    end
                    sh_d.state = RD_IDLE;
                    sh_d.sdo   = 1'b1;
                end
                default: sh_d.state = RD_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= SH_RST;
        else        sh_q <= sh_d;
    end

    assign sdo_o  = sh_q.sdo;
    assign busy_o = (sh_q.state == RD_READY) || (sh_q.state == RD_SHIFT);

    // R4: the line rests high with nothing offered and low while offered
    p_idle_level_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (sh_q.state == RD_IDLE) |-> sh_q.sdo);
    p_ready_level_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (sh_q.state == RD_READY) |-> !sh_q.sdo);
    // R5: never more than one word of bits per result
    p_bit_budget_r5: assert property (@(posedge clk) disable iff (!rst_n)
        sh_q.falls <= BIT_COUNT);
    // R6: data moves only with a falling serial edge
    p_data_steady_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && (sh_q.state == RD_SHIFT) && !fall_i && !rise_i)
        |=> $stable(sh_q.sdo));
    // R9: a result landing mid-readout is parked
    p_park_result_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && busy_o && done_i) |=> sh_q.pend);
    // R10: standby leaves nothing behind
    p_standby_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |=> ((sh_q.state == RD_IDLE) && !sh_q.pend));
endmodule

// File: rtl/ro_adc_serial_port.sv
module ro_adc_serial_port #(
    parameter int DATA_W      = 24,
    parameter int CONV_CYCLES = 1656,
    parameter int GAIN_SHIFT  = 4,
    parameter int HALF_DIV    = 1,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              mode_slave,
    input  logic              chan_sel,
    input  logic              range_sel,
    input  logic [DATA_W-1:0] sample_a,
    input  logic [DATA_W-1:0] sample_b,
    input  logic              sclk_i,
    output logic              sclk_o,
    output logic              sclk_oe,
    output logic              sdo_o,
    output logic              sdo_oe
);
    logic              conv_done;
    logic [DATA_W-1:0] conv_data;
    logic              rd_busy;
    logic              gen_active;
    logic              m_fall, m_rise;
    logic              s_fall, s_rise;
    logic              edge_fall, edge_rise;

    adcro_conv_timer #(
        .DATA_W     (DATA_W),
        .CONV_CYCLES(CONV_CYCLES),
        .GAIN_SHIFT (GAIN_SHIFT)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .cs_n     (cs_n),
        .chan_sel (chan_sel),
        .range_sel(range_sel),
        .sample_a (sample_a),
        .sample_b (sample_b),
        .done_o   (conv_done),
        .data_o   (conv_data)
    );

    assign gen_active = rd_busy && !mode_slave && !cs_n;

    adcro_master_clk #(
        .HALF_DIV(HALF_DIV)
    ) u_mclk (
        .clk     (clk),
        .rst_n   (rst_n),
        .active_i(gen_active),
        .sclk_o  (sclk_o),
        .fall_o  (m_fall),
        .rise_o  (m_rise)
    );

    adcro_slave_sync #(
        .SYNC_STAGES(SYNC_STAGES)
    ) u_ssync (
        .clk   (clk),
        .rst_n (rst_n),
        .sclk_i(sclk_i),
        .fall_o(s_fall),
        .rise_o(s_rise)
    );

    assign edge_fall = mode_slave ? s_fall : m_fall;
    assign edge_rise = mode_slave ? s_rise : m_rise;

    adcro_shifter #(
        .DATA_W(DATA_W)
    ) u_shift (
        .clk   (clk),
        .rst_n (rst_n),
        .cs_n  (cs_n),
        .done_i(conv_done),
        .data_i(conv_data),
        .fall_i(edge_fall),
        .rise_i(edge_rise),
        .sdo_o (sdo_o),
        .busy_o(rd_busy)
    );

    // R10: pin drivers follow the select directly; R7: host owns the clock in slave mode
    assign sdo_oe  = !cs_n;
    assign sclk_oe = !cs_n && !mode_slave;
endmodule

// File: tb/tb_ro_adc_serial_port.sv
module tb_ro_adc_serial_port;
    localparam int CLK_PERIOD = 10;
    localparam int DW         = 24;
    localparam int CONV       = 400;
    localparam int HALF       = 2;
    localparam int SLOW_HALF  = 10;
    localparam int FAST_HALF  = 6;
    localparam int WATCHDOG   = 190000;
    localparam longint MID    = 64'sd1 <<< (DW - 1);

    logic          clk = 1'b0;
    logic          rst_n;
    logic          cs_n, mode_slave, chan_sel, range_sel, sclk_i;
    logic [DW-1:0] sample_a, sample_b;
    logic          sclk_o, sclk_oe, sdo_o, sdo_oe;

    int n_checks = 0;
    int n_fails  = 0;
    int cyc      = 0;
    bit finished = 0;

    ro_adc_serial_port #(.DATA_W(DW), .CONV_CYCLES(CONV), .GAIN_SHIFT(4),
                         .HALF_DIV(HALF), .SYNC_STAGES(2)) dut (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .mode_slave(mode_slave),
        .chan_sel(chan_sel), .range_sel(range_sel), .sample_a(sample_a),
        .sample_b(sample_b), .sclk_i(sclk_i), .sclk_o(sclk_o),
        .sclk_oe(sclk_oe), .sdo_o(sdo_o), .sdo_oe(sdo_oe));

    always #(CLK_PERIOD / 2) clk = ~clk;

    always @(posedge clk) begin
        cyc++;
        if (cyc > WATCHDOG && !finished) begin
            finished = 1;
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual %0d cycles expected below %0d", cyc, WATCHDOG);
            $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
            $finish;
        end
    end

    task automatic check(input string req, input string what,
                         input longint act, input longint exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [DW-1:0] expect_code(input logic [DW-1:0] v, input bit rng);
        longint s;
        s = longint'(v) - MID;
        if (rng) s = s * 16;
        if (s > MID - 1) s = MID - 1;
        if (s < -MID) s = -MID;
        return DW'(s + MID);
    endfunction

    task automatic wait_ready(output int waited);
        waited = 0;
        while (sdo_o !== 1'b0 && waited < 3 * CONV) begin
            @(negedge clk);
            waited++;
        end
        if (waited >= 3 * CONV) check("R4", "ready timeout", waited, 0);
    endtask

    task automatic read_master(output logic [DW-1:0] val, output int edges,
                               output int extra, output logic after_sdo);
        logic prev;
        val = '0; edges = 0; extra = 0;
        prev = sclk_o;
        for (int c = 0; c < 4000 && edges < DW; c++) begin
            @(negedge clk);
            if (!prev && sclk_o) begin
                val = {val[DW-2:0], sdo_o};
                edges++;
            end
            prev = sclk_o;
        end
        @(negedge clk);
        after_sdo = sdo_o;
        prev = sclk_o;
        for (int c = 0; c < 8 * HALF + 8; c++) begin
            @(negedge clk);
            if (!prev && sclk_o) extra++;
            prev = sclk_o;
        end
    endtask

    task automatic read_slave(input int half, input int nbits, inout logic [DW-1:0] val);
        for (int i = 0; i < nbits; i++) begin
            sclk_i = 1'b0;
            tick(half);
            val = {val[DW-2:0], sdo_o};
            sclk_i = 1'b1;
            tick(half);
        end
    endtask

    localparam logic [DW-1:0] PATS [10] = '{
        24'h000000, 24'hFFFFFF, 24'h800000, 24'h800001, 24'h7FFFFF,
        24'h87FFFF, 24'h880000, 24'h780000, 24'h77FFFF, 24'h123456};

    initial begin
        logic [DW-1:0] val;
        logic          after;
        int            edges, extra, waited, t_first, bad;

        rst_n = 0; cs_n = 1; mode_slave = 0; chan_sel = 0; range_sel = 0;
        sclk_i = 1; sample_a = '0; sample_b = '0;
        tick(5);
        check("R10", "reset sdo_oe", sdo_oe, 0);
        check("R10", "reset sclk_oe", sclk_oe, 0);
        check("R4", "reset sdo level", sdo_o, 1);
        check("R5", "reset sclk level", sclk_o, 1);
        rst_n = 1;
        tick(3);

        // R3/R5/R8: exact first latency, master readout, period
        sample_a = 24'h123456;
        cs_n = 0;
        tick(CONV);
        check("R4", "sdo before first result", sdo_o, 1);
        tick(1);
        check("R3", "sdo at first result", sdo_o, 0);
        t_first = cyc;
        check("R5", "sclk_oe master", sclk_oe, 1);
        check("R10", "sdo_oe selected", sdo_oe, 1);
        read_master(val, edges, extra, after);
        check("R6", "master word", val, 24'h123456);
        check("R5", "rising edges", edges, DW);
        check("R8", "sdo after last bit", after, 1);
        check("R5", "extra edges", extra, 0);
        wait_ready(waited);
        check("R3", "result period", cyc - t_first, CONV);
        cs_n = 1;
        tick(1);
        check("R10", "standby sdo_oe", sdo_oe, 0);
        check("R10", "standby sclk_oe", sclk_oe, 0);
        tick(3);

        // R1/R2/R6: sweep codes, ranges, channels and both modes
        for (int m = 0; m < 2; m++) begin
            for (int i = 0; i < 10; i++) begin
                for (int r = 0; r < 2; r++) begin
                    mode_slave = m[0]; range_sel = r[0]; chan_sel = i[0];
                    sample_a = PATS[i];
                    sample_b = PATS[i] ^ 24'h5A5A5A;
                    tick(2);
                    cs_n = 0;
                    wait_ready(waited);
                    val = '0;
                    if (m == 0) read_master(val, edges, extra, after);
                    else        read_slave(FAST_HALF, DW, val);
                    check(r == 1 ? "R1" : "R2", $sformatf("sweep m%0d i%0d", m, i), val,
                          expect_code(chan_sel ? sample_b : sample_a, range_sel));
                    cs_n = 1;
                    tick(3);
                end
            end
        end

        // R2: pin change during a conversion applies to the next one only
        mode_slave = 0; range_sel = 0; chan_sel = 0;
        sample_a = 24'hA1B2C3; sample_b = 24'h0F0E0D;
        tick(2);
        cs_n = 0;
        tick(100);
        chan_sel = 1;
        wait_ready(waited);
        read_master(val, edges, extra, after);
        check("R2", "channel latched at start", val, 24'hA1B2C3);
        wait_ready(waited);
        read_master(val, edges, extra, after);
        check("R2", "channel on next conversion", val, 24'h0F0E0D);
        cs_n = 1;
        tick(3);

        // R7: slave mode, host clock, extra pulses ignored
        mode_slave = 1; chan_sel = 0; sample_a = 24'h3C5AF1;
        tick(2);
        cs_n = 0;
        tick(1);
        check("R7", "slave sclk_oe", sclk_oe, 0);
        check("R7", "slave sdo_oe", sdo_oe, 1);
        wait_ready(waited);
        val = '0;
        read_slave(FAST_HALF, DW, val);
        check("R7", "slave word", val, 24'h3C5AF1);
        check("R8", "slave sdo after last bit", sdo_o, 1);
        bad = 0;
        for (int k = 0; k < 3; k++) begin
            sclk_i = 0;
            tick(FAST_HALF);
            if (sdo_o !== 1'b1) bad++;
            sclk_i = 1;
            tick(FAST_HALF);
        end
        check("R7", "extra pulses moved sdo", bad, 0);
        wait_ready(waited);
        val = '0;
        read_slave(FAST_HALF, DW, val);
        check("R7", "word after extra pulses", val, 24'h3C5AF1);
        cs_n = 1;
        tick(3);

        // R9: result arriving mid-readout is parked, not mixed in
        mode_slave = 1; sample_a = 24'hC0FFEE;
        tick(2);
        cs_n = 0;
        wait_ready(waited);
        val = '0;
        read_slave(SLOW_HALF, 8, val);
        sample_a = 24'h13579B;
        read_slave(SLOW_HALF, DW - 8, val);
        check("R9", "word during pending", val, 24'hC0FFEE);
        wait_ready(waited);
        check("R9", "parked result promptly ready", (waited < 20) ? 1 : 0, 1);
        val = '0;
        read_slave(FAST_HALF, DW, val);
        check("R9", "parked word", val, 24'h13579B);
        cs_n = 1;
        tick(3);

        // R10: abort during a readout discards the result
        mode_slave = 1; sample_a = 24'hA5C3F0;
        tick(2);
        cs_n = 0;
        wait_ready(waited);
        val = '0;
        read_slave(FAST_HALF, 5, val);
        cs_n = 1;
        tick(1);
        check("R10", "abort sdo_oe", sdo_oe, 0);
        check("R10", "abort sclk_oe", sclk_oe, 0);
        tick(2);
        cs_n = 0;
        tick(CONV);
        check("R10", "discarded result not offered", sdo_o, 1);
        tick(1);
        check("R3", "ready after reselect", sdo_o, 0);
        val = '0;
        read_slave(FAST_HALF, DW, val);
        check("R10", "fresh word from MSB", val, 24'hA5C3F0);
        cs_n = 1;
        tick(3);

        // R10: abort mid-conversion restarts the timer
        mode_slave = 0; sample_a = 24'h5EED42;
        tick(2);
        cs_n = 0;
        tick(150);
        cs_n = 1;
        tick(2);
        cs_n = 0;
        tick(CONV);
        check("R10", "timer restarted, not ready", sdo_o, 1);
        tick(1);
        check("R10", "timer restarted, ready", sdo_o, 0);
        read_master(val, edges, extra, after);
        check("R6", "word after restart", val, 24'h5EED42);
        cs_n = 1;
        tick(3);

        finished = 1;
        $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
        $finish;
    end
endmodule